// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This peripheral keeps time as a 32-bit count of whole seconds. A prescaler divides the system clock down to a one-cycle pulse every `TICK_DIV` clock cycles. That pulse is the one-second tick, and the seconds counter changes only on it. Software talks to the block over a simple APB-style register bus. It sets the time by writing a load register, and it arms an alarm by writing a match register.

When the seconds count reaches the match value, a sticky raw alarm flag sets. An enable bit and a mask bit in the control register gate this flag onto the single interrupt output. Software can poll the raw flag or the gated flag. It clears the alarm by reading a dedicated end-of-interrupt register. A read-only identification register returns a fixed value set by a parameter.

Top module: `sec_rtc`

## Requirements
- R1: While counter enable (control bit 2) is set, the seconds count (offset 0x00) rises by exactly one every `TICK_DIV` clock cycles. While counter enable is clear, the count does not change and the prescaler restarts from zero.
- R2: A write to the load register (offset 0x08) leaves the seconds count unchanged until the next tick. On that tick the count takes the written value instead of incrementing, and later ticks increment from it. The load register reads back the last value written.
- R3: On a tick whose new count equals the match register (offset 0x04), raw status bit 0 (offset 0x14) sets. It stays set through later ticks until it is cleared.
- R4: A read of offset 0x18 returns 0 and clears raw status bit 0. A tick that sets the flag in the same cycle takes priority over the clear.
- R5: Masked status bit 0 (offset 0x10) and the `irq` output both equal raw status AND interrupt enable (control bit 0) AND NOT interrupt mask (control bit 1).
- R6: On a tick at count 0xFFFFFFFF, the count becomes 0 if wrap enable (control bit 3) is set. If wrap enable is clear, the count stays at 0xFFFFFFFF.
- R7: The control register (offset 0x0C) reads back bits 3:0 as last written, and its upper bits read as 0.
- R8: Offset 0x1C always reads `VERSION`. Writes to offsets 0x00, 0x10, 0x14, 0x18 and 0x1C change no register.
- R9: After reset, every register reads 0 except offset 0x1C, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address; bits 4:2 pick the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Gated alarm interrupt |

## Verification
If the prescaler phase is wrong, the count changes one or more cycles early or late. That shifts the count read right after a bounded run of ticks by one. A load request that is lost or applied too early shows up at the very next read of offset 0x00. This happens either before any tick or one tick later, as a value that is off by one or has not been replaced. A wrong alarm flag shows on `irq` and offsets 0x10 and 0x14 within one cycle of the tick or the end-of-interrupt read that should have moved it.

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int unsigned TICK_DIV = 32768,
  parameter logic [31:0] VERSION  = 32'h0001_0000,
  parameter int unsigned AW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          irq
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  localparam logic [2:0] A_CNT  = 3'd0;
  localparam logic [2:0] A_MAT  = 3'd1;
  localparam logic [2:0] A_LOAD = 3'd2;
  localparam logic [2:0] A_CTL  = 3'd3;
  localparam logic [2:0] A_MST  = 3'd4;
  localparam logic [2:0] A_RST  = 3'd5;
  localparam logic [2:0] A_EOI  = 3'd6;
  localparam logic [2:0] A_VER  = 3'd7;

  logic [PW-1:0] pre_q;
  logic [31:0]   cnt_q, match_q, load_q, cnt_next;
  logic [3:0]    ctl_q;
  logic          load_pend, raw_q;

  logic [2:0] sel;
  logic       rd, wr, tick, eoi, ie, msk, en, wrap, masked;

  assign sel    = paddr[4:2];
  assign wr     = psel & penable & pwrite;
  assign rd     = psel & penable & ~pwrite;
  assign ie     = ctl_q[0];
  assign msk    = ctl_q[1];
  assign en     = ctl_q[2];
  assign wrap   = ctl_q[3];
  assign tick   = en && (pre_q == PRE_LAST);
  assign eoi    = rd && (sel == A_EOI);
  assign masked = raw_q & ie & ~msk;
  assign irq    = masked;

  always_comb begin
    if (load_pend)  cnt_next = load_q;
    else if (&cnt_q) cnt_next = wrap ? 32'd0 : cnt_q;
    else            cnt_next = cnt_q + 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (!en || tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      match_q   <= '0;
      load_q    <= '0;
      load_pend <= 1'b0;
      ctl_q     <= '0;
    end else begin
      if (tick) cnt_q <= cnt_next;
      if (wr && sel == A_MAT) match_q <= pwdata;
      if (wr && sel == A_CTL) ctl_q <= pwdata[3:0];
      if (wr && sel == A_LOAD) begin
        load_q    <= pwdata;
        load_pend <= 1'b1;
      end else if (tick) begin
        load_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          raw_q <= 1'b0;
    else if (tick && cnt_next == match_q) raw_q <= 1'b1;
    else if (eoi)                        raw_q <= 1'b0;
  end

  always_comb begin
    case (sel)
      A_CNT:   prdata = cnt_q;
      A_MAT:   prdata = match_q;
      A_LOAD:  prdata = load_q;
      A_CTL:   prdata = {28'd0, ctl_q};
      A_MST:   prdata = {31'd0, masked};
      A_RST:   prdata = {31'd0, raw_q};
      A_EOI:   prdata = 32'd0;
      A_VER:   prdata = VERSION;
      default: prdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        en,
  input logic        wrap,
  input logic        eoi,
  input logic        load_pend,
  input logic [31:0] load_q,
  input logic [31:0] cnt_q,
  input logic        raw_q
);
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R1
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick); // R1
  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick && load_pend |=> cnt_q == $past(load_q)); // R2
  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q && !eoi |=> raw_q); // R3
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !tick |=> !raw_q); // R4
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load_pend && (&cnt_q) && !wrap |=> &cnt_q); // R6
  AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load_pend && (&cnt_q) && wrap |=> cnt_q == 32'd0); // R6
endmodule

bind sec_rtc sec_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .wrap(wrap), .eoi(eoi),
  .load_pend(load_pend), .load_q(load_q), .cnt_q(cnt_q), .raw_q(raw_q)
);

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;
  localparam int unsigned DIV = 4;
  localparam logic [31:0] VER = 32'hA5C3_0102;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  sec_rtc #(.TICK_DIV(DIV), .VERSION(VER), .AW(5)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  // enable counting with control bits cbits for exactly k ticks, then stop
  task automatic run_ticks(input int k, input logic [3:0] cbits);
    wr(5'h0C, {28'd0, cbits | 4'b0100});
    repeat (k * DIV - 1) @(posedge clk);
    #1 wr(5'h0C, {28'd0, cbits & 4'b1011});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 reset state
    for (int a = 0; a < 7; a++) begin
      rd(5'(a * 4), v); check("R9 reset reg", v, 32'd0);
    end
    check("R9 irq after reset", {31'd0, irq}, 32'd0);
    rd(5'h1C, v); check("R8 version", v, VER);

    // R7 control readback sweep (counter enable kept clear)
    for (int b = 0; b < 16; b++) begin
      if (b[2]) continue;
      wr(5'h0C, 32'hFFFF_FFF0 | 32'(b));
      rd(5'h0C, v); check("R7 control readback", v, 32'(b));
    end
    wr(5'h0C, 32'd0);

    // R8 writes to read-only offsets ignored
    wr(5'h00, 32'hDEAD_BEEF); wr(5'h10, 32'hFFFF_FFFF); wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF); wr(5'h1C, 32'h1234_5678);
    rd(5'h00, v); check("R8 count unchanged", v, 32'd0);
    rd(5'h14, v); check("R8 raw unchanged", v, 32'd0);
    rd(5'h1C, v); check("R8 version unchanged", v, VER);
    rd(5'h04, v); check("R8 match unchanged", v, 32'd0);
    rd(5'h08, v); check("R8 load unchanged", v, 32'd0);

    // R1 tick counting sweep
    c = 0;
    for (int k = 1; k <= 5; k++) begin
      run_ticks(k, 4'b0000); c += 32'(k);
      rd(5'h00, v); check("R1 count after k ticks", v, c);
    end
    repeat (20) @(posedge clk);
    rd(5'h00, v); check("R1 count frozen while disabled", v, c);

    // R2 deferred load sweep
    wr(5'h04, 32'hFFFF_0000);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] lv;
      lv = 32'h100 * 32'(i + 1) + 32'(i);
      wr(5'h08, lv);
      rd(5'h00, v); check("R2 count not loaded before tick", v, c);
      rd(5'h08, v); check("R2 load readback", v, lv);
      run_ticks(1, 4'b0000);
      rd(5'h00, v); check("R2 load applied on tick", v, lv);
      run_ticks(2, 4'b0000);
      rd(5'h00, v); check("R2 count resumes after load", v, lv + 2);
      c = lv + 2;
    end

    // R3 / R5 alarm and gating
    wr(5'h04, c + 2);
    run_ticks(1, 4'b0001);
    rd(5'h14, v); check("R3 raw clear before match", v, 32'd0);
    check("R5 irq low before match", {31'd0, irq}, 32'd0);
    run_ticks(1, 4'b0001);
    rd(5'h14, v); check("R3 raw set on match", v, 32'd1);
    run_ticks(2, 4'b0001);
    rd(5'h14, v); check("R3 raw sticky past match", v, 32'd1);
    c += 4;
    for (int b = 0; b < 4; b++) begin
      wr(5'h0C, 32'(b));
      rd(5'h10, v); check("R5 masked status", v, {31'd0, b == 1});
      check("R5 irq pin", {31'd0, irq}, {31'd0, b == 1});
    end
    wr(5'h0C, 32'd1);

    // R4 end-of-interrupt
    rd(5'h18, v); check("R4 eoi read data", v, 32'd0);
    rd(5'h14, v); check("R4 raw cleared", v, 32'd0);
    check("R4 irq cleared", {31'd0, irq}, 32'd0);

    // R3 match reached through a load
    wr(5'h04, 32'h0000_5555); wr(5'h08, 32'h0000_5555);
    run_ticks(1, 4'b0001);
    rd(5'h14, v); check("R3 match via load", v, 32'd1);
    rd(5'h18, v);

    // R6 saturate and rollover
    wr(5'h08, 32'hFFFF_FFFE);
    run_ticks(1, 4'b0000);
    run_ticks(1, 4'b0000);
    rd(5'h00, v); check("R6 reach max", v, 32'hFFFF_FFFF);
    run_ticks(3, 4'b0000);
    rd(5'h00, v); check("R6 hold at max without wrap", v, 32'hFFFF_FFFF);
    run_ticks(1, 4'b1000);
    rd(5'h00, v); check("R6 roll to zero with wrap", v, 32'd0);
    run_ticks(2, 4'b1000);
    rd(5'h00, v); check("R6 count after rollover", v, 32'd2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule